// File: doc/BRIEF.md
# Bandwidth Slot Allocation Engine

This block builds a slot ownership table for a time-sliced memory arbiter. Each table entry names the client that owns one service slot. Every client has two inputs: a requested slot count and an active flag. A separate input gives the budget of unassigned slots. A one-cycle start pulse captures all of these inputs. The engine then fills the table in three stages:

- Clients with a nonzero request are spread evenly across the table.
- Active clients with a zero request receive one spare slot each, while the budget lasts.
- Every slot still empty is handed out round-robin among the active clients.

When the table is complete, the engine streams it out one entry per cycle, from slot 0 upward. Each entry comes with a write strobe, so the arbiter's slot registers can be loaded directly. A single done pulse marks the end of the stream. Checking whether the requests fit within the table is left to the caller.

Top module: `slot_alloc_engine`

## Requirements
- R1: After reset, busy, wr_en and done are all low.
- R2: A start pulse while idle raises busy on the next cycle and captures req_cnt, active and spare_cnt. A start pulse while busy is ignored, and the table then produced follows the inputs captured at the accepted start.
- R3: A client with nonzero request R is placed with an interval of floor(NUM_SLOTS/R). The scan begins at slot 0. An occupied slot advances the scan by one. A free slot is taken and advances the scan by the interval, until the scan passes the last slot.
- R4: Clients are handled in ascending index order (the request for client i sits at req_cnt bits [i*REQ_W +: REQ_W]), so lower indexes claim contested slots first.
- R5: An active client (active bit i set) whose request is zero takes the first free slot, but only while the spare budget is above zero, and each such grant lowers the budget by one. An inactive zero-request client takes no slot in this stage.
- R6: After placement, each free slot, in ascending order, goes to the next active client in round-robin order. The round-robin pointer starts at client 0 and advances past each client it assigns.
- R7: When no client is active, the round-robin search gives up after a full lap and assigns the client it started from. The leftover slots then cycle through 0, 1, ..., NUM_CLIENTS-1.
- R8: The result is streamed as NUM_SLOTS strobes on wr_en in consecutive cycles, with wr_slot counting up from 0. wr_client is always a valid client index below NUM_CLIENTS.
- R9: done pulses for exactly one cycle, in the cycle after the last strobe. busy is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; captures inputs when idle |
| req_cnt | input | NUM_CLIENTS*REQ_W | Packed requested slot count per client |
| active | input | NUM_CLIENTS | Per-client active flag |
| spare_cnt | input | REQ_W | Budget of unassigned slots for zero-request clients |
| busy | output | 1 | High from the accepted start until done |
| wr_en | output | 1 | Write strobe for one table entry |
| wr_slot | output | SLOT_W | Slot index of the streamed entry |
| wr_client | output | CLI_W | Owner client of the streamed entry |
| done | output | 1 | One-cycle pulse after the last entry |

## Verification
The bench builds the engine with NUM_SLOTS=64 and NUM_CLIENTS=6.

The full 64-entry table keeps the real stride arithmetic in play, including non-divisor requests such as 3 (stride 21) and the extremes of 1 and 64. The small client count makes round-robin wraparound frequent, and it keeps the all-inactive search lap short enough to observe in every slot.

Each scenario covers one of the following:
- contested placement;
- a spare budget that runs out partway through;
- a start pulse issued during a run, with different inputs applied.

// File: rtl/slotalloc_pkg.sv
package slotalloc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_DIV,
    ST_PLACE,
    ST_FILL,
    ST_OUT,
    ST_TAIL
  } eng_state_e;
endpackage

// File: rtl/slot_div.sv
module slot_div #(
  parameter int DIVIDEND = 64,
  parameter int W        = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic         ready
);
  logic [W-1:0] rem;
  logic [W-1:0] dvs_q;
  logic         run;

  // repeated subtraction: at most DIVIDEND iterations, no combinational divide
  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      ready <= 1'b0;
      rem   <= '0;
      quot  <= '0;
      dvs_q <= '0;
    end else begin
      ready <= 1'b0;
      if (go) begin
        rem   <= W'(DIVIDEND);
        quot  <= '0;
        dvs_q <= divisor;
        run   <= 1'b1;
      end else if (run) begin
        if (rem >= dvs_q) begin
          rem  <= rem - dvs_q;
          quot <= quot + 1'b1;
        end else begin
          run   <= 1'b0;
          ready <= 1'b1;
        end
      end
    end
  end

  // R3: the quotient is the floor of DIVIDEND / divisor
  p_quot_floor_r3: assert property (@(posedge clk) disable iff (rst)
    ready |-> ((2*W)'(quot) * (2*W)'(dvs_q) <= (2*W)'(DIVIDEND)) &&
              ((2*W)'(quot) * (2*W)'(dvs_q) + (2*W)'(dvs_q) > (2*W)'(DIVIDEND)));
endmodule

// File: rtl/slot_ram.sv
module slot_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/slot_alloc_engine.sv
module slot_alloc_engine
  import slotalloc_pkg::*;
#(
  parameter int NUM_SLOTS   = 64,
  parameter int NUM_CLIENTS = 15,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int REQ_W  = $clog2(NUM_SLOTS + 1),
  localparam int CLI_W  = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [NUM_CLIENTS*REQ_W-1:0] req_cnt,
  input  logic [NUM_CLIENTS-1:0]       active,
  input  logic [REQ_W-1:0]             spare_cnt,
  output logic                         busy,
  output logic                         wr_en,
  output logic [SLOT_W-1:0]            wr_slot,
  output logic [CLI_W-1:0]             wr_client,
  output logic                         done
);
  localparam int PTR_W = SLOT_W + 1;
  localparam logic [CLI_W-1:0]  LAST_CLI  = CLI_W'(NUM_CLIENTS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [PTR_W-1:0]  SLOT_END  = PTR_W'(NUM_SLOTS);

  eng_state_e state;

  logic [REQ_W-1:0]     req_q [NUM_CLIENTS];
  logic [NUM_CLIENTS-1:0] act_q;
  logic [REQ_W-1:0]     spare_q;
  logic [NUM_SLOTS-1:0] occ;
  logic [CLI_W-1:0]     cur, rr, first;
  logic                 hunting;
  logic [PTR_W-1:0]     pos, fidx;
  logic [REQ_W-1:0]     step;
  logic [SLOT_W-1:0]    oidx;
  logic                 v1;
  logic [SLOT_W-1:0]    s1;

  logic                 ram_we;
  logic [SLOT_W-1:0]    ram_wa, ram_ra;
  logic [CLI_W-1:0]     ram_wd, rd_q;
  logic                 div_go, div_ready;
  logic [REQ_W-1:0]     div_quot;
  logic [REQ_W-1:0]     cur_req;
  logic [CLI_W-1:0]     rr_nxt, first_eff, first_nxt;
  logic                 last_cli, pos_in, fidx_in;

  slot_div #(.DIVIDEND(NUM_SLOTS), .W(REQ_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .divisor(cur_req),
    .quot(div_quot), .ready(div_ready)
  );

  slot_ram #(.DEPTH(NUM_SLOTS), .AW(SLOT_W), .DW(CLI_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(ram_wd),
    .raddr(ram_ra), .rdata(rd_q)
  );

  always_comb begin
    cur_req   = req_q[cur];
    last_cli  = (cur == LAST_CLI);
    rr_nxt    = (rr == LAST_CLI) ? '0 : rr + 1'b1;
    first_eff = hunting ? first : rr;
    first_nxt = (first_eff == LAST_CLI) ? '0 : first_eff + 1'b1;
    pos_in    = (pos < SLOT_END);
    fidx_in   = (fidx < SLOT_END);
    div_go    = (state == ST_PICK) && (cur_req != '0);
    ram_ra    = oidx;
    ram_we    = 1'b0;
    ram_wa    = pos[SLOT_W-1:0];
    ram_wd    = cur;
    if (state == ST_PLACE) begin
      ram_we = pos_in && !occ[pos[SLOT_W-1:0]];
    end else if (state == ST_FILL) begin
      ram_wa = fidx[SLOT_W-1:0];
      if (fidx_in && !occ[fidx[SLOT_W-1:0]]) begin
        if (act_q[rr]) begin
          ram_we = 1'b1;
          ram_wd = rr;
        end else if (rr_nxt == first_eff) begin
          ram_we = 1'b1;
          ram_wd = first_eff;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      wr_en     <= 1'b0;
      wr_slot   <= '0;
      wr_client <= '0;
      done      <= 1'b0;
      v1        <= 1'b0;
      s1        <= '0;
      occ       <= '0;
      cur       <= '0;
      rr        <= '0;
      first     <= '0;
      hunting   <= 1'b0;
      pos       <= '0;
      fidx      <= '0;
      step      <= '0;
      oidx      <= '0;
      spare_q   <= '0;
      act_q     <= '0;
      for (int i = 0; i < NUM_CLIENTS; i++) req_q[i] <= '0;
    end else begin
      v1        <= 1'b0;
      wr_en     <= v1;
      wr_slot   <= s1;
      wr_client <= rd_q;
      done      <= wr_en && (wr_slot == LAST_SLOT);
      case (state)
        ST_IDLE: if (start) begin
          for (int i = 0; i < NUM_CLIENTS; i++) req_q[i] <= req_cnt[i*REQ_W +: REQ_W];
          act_q   <= active;
          spare_q <= spare_cnt;
          occ     <= '0;
          cur     <= '0;
          busy    <= 1'b1;
          state   <= ST_PICK;
        end
        ST_PICK: begin
          pos <= '0;
          if (cur_req != '0) begin
            state <= ST_DIV;
          end else if (act_q[cur] && spare_q != '0) begin
            spare_q <= spare_q - 1'b1;
            step    <= REQ_W'(NUM_SLOTS);
            state   <= ST_PLACE;
          end else if (last_cli) begin
            fidx <= '0; rr <= '0; hunting <= 1'b0; state <= ST_FILL;
          end else begin
            cur <= cur + 1'b1;
          end
        end
        ST_DIV: if (div_ready) begin
          step  <= div_quot;
          state <= ST_PLACE;
        end
        ST_PLACE: begin
          if (!pos_in) begin
            if (last_cli) begin
              fidx <= '0; rr <= '0; hunting <= 1'b0; state <= ST_FILL;
            end else begin
              cur   <= cur + 1'b1;
              state <= ST_PICK;
            end
          end else if (occ[pos[SLOT_W-1:0]]) begin
            pos <= pos + 1'b1;
          end else begin
            occ[pos[SLOT_W-1:0]] <= 1'b1;
            pos <= pos + PTR_W'(step);
          end
        end
        ST_FILL: begin
          if (!fidx_in) begin
            oidx  <= '0;
            state <= ST_OUT;
          end else if (occ[fidx[SLOT_W-1:0]]) begin
            fidx <= fidx + 1'b1;
          end else if (act_q[rr]) begin
            fidx <= fidx + 1'b1; rr <= rr_nxt; hunting <= 1'b0;
          end else if (rr_nxt == first_eff) begin
            fidx <= fidx + 1'b1; rr <= first_nxt; hunting <= 1'b0;
          end else begin
            first <= first_eff; hunting <= 1'b1; rr <= rr_nxt;
          end
        end
        ST_OUT: begin
          v1   <= 1'b1;
          s1   <= oidx;
          oidx <= oidx + 1'b1;
          if (oidx == LAST_SLOT) state <= ST_TAIL;
        end
        ST_TAIL: if (wr_en && wr_slot == LAST_SLOT) begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  p_strobe_busy_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);
  p_client_range_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_client) < NUM_CLIENTS));
  p_slot_seq_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_slot == $past(wr_slot) + 1'b1));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/sim_slot_alloc_engine.sv
module sim_slot_alloc_engine;
  localparam int NS    = 64;
  localparam int NC    = 6;
  localparam int REQ_W = $clog2(NS + 1);
  localparam int SW    = $clog2(NS);
  localparam int CW    = $clog2(NC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NC*REQ_W-1:0] req_cnt = '0;
  logic [NC-1:0]       active = '0;
  logic [REQ_W-1:0]    spare_cnt = '0;
  logic busy, wr_en, done;
  logic [SW-1:0] wr_slot;
  logic [CW-1:0] wr_client;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int strobes = 0;
  string tag = "R1";
  int exp_slot[$];
  int exp_cli[$];

  always #5 clk = ~clk;

  slot_alloc_engine #(.NUM_SLOTS(NS), .NUM_CLIENTS(NC)) u0 (
    .clk(clk), .rst(rst), .start(start), .req_cnt(req_cnt), .active(active),
    .spare_cnt(spare_cnt), .busy(busy), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_client(wr_client), .done(done)
  );

  task automatic check(input string t, input int act_v, input int exp_v, input string what);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act_v, exp_v);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      strobes++;
      if (exp_slot.size() == 0) begin
        check("R8", 1, 0, "unexpected strobe");
      end else begin
        int es, ec;
        es = exp_slot.pop_front();
        ec = exp_cli.pop_front();
        check("R8", int'(wr_slot), es, "slot order");
        check(tag, int'(wr_client), ec, $sformatf("owner of slot %0d", es));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic void model(input int rq[NC], input bit ac[NC], input int sp_in);
    int v[NS];
    int sp, iv, pos, c, first;
    sp = sp_in;
    for (int s = 0; s < NS; s++) v[s] = -1;
    for (int k = 0; k < NC; k++) begin
      if (rq[k] == 0) begin
        if (!ac[k] || sp <= 0) continue;
        sp--;
        iv = NS;
      end else iv = NS / rq[k];
      pos = 0;
      while (pos < NS) begin
        if (v[pos] >= 0) pos++;
        else begin v[pos] = k; pos += iv; end
      end
    end
    c = 0;
    for (int s = 0; s < NS; s++) begin
      if (v[s] < 0) begin
        first = c;
        while (!ac[c]) begin
          c = (c + 1) % NC;
          if (c == first) break;
        end
        v[s] = c;
        c = (c + 1) % NC;
      end
      exp_slot.push_back(s);
      exp_cli.push_back(v[s]);
    end
  endfunction

  task automatic apply(input int rq[NC], input bit ac[NC], input int sp);
    for (int k = 0; k < NC; k++) begin
      req_cnt[k*REQ_W +: REQ_W] = REQ_W'(rq[k]);
      active[k] = ac[k];
    end
    spare_cnt = REQ_W'(sp);
  endtask

  task automatic run_case(input string t, input int rq[NC], input bit ac[NC],
                          input int sp, input bit poke);
    int n;
    tag = t;
    strobes = 0;
    model(rq, ac, sp);
    @(negedge clk);
    apply(rq, ac, sp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", int'(busy), 1, "busy after start");
    if (poke) begin
      int alt_rq[NC];
      bit alt_ac[NC];
      for (int k = 0; k < NC; k++) begin alt_rq[k] = 0; alt_ac[k] = 1'b1; end
      alt_rq[NC-1] = 64;
      repeat (10) @(negedge clk);
      apply(alt_rq, alt_ac, 9);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check("R9", int'(done), 1, "done seen");
    check("R9", int'(busy), 0, "busy low with done");
    check("R8", strobes, NS, "strobe count");
    check(t, exp_slot.size(), 0, "entries left unchecked");
    exp_slot.delete();
    exp_cli.delete();
    @(negedge clk);
    check("R9", int'(done), 0, "done single pulse");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(busy), 0, "busy at reset");
    check("R1", int'(wr_en), 0, "wr_en at reset");
    check("R1", int'(done), 0, "done at reset");
    // R3: non-divisor stride 21, rest shared by clients 0 and 1
    run_case("R3", '{3,0,0,0,0,0}, '{1,1,0,0,0,0}, 0, 1'b0);
    // R4: contested placement, low index wins
    run_case("R4", '{8,4,2,0,0,0}, '{1,1,1,0,0,0}, 50, 1'b0);
    // R5: two spare grants, inactive zero-request client 2 skipped
    run_case("R5", '{16,0,0,0,8,0}, '{1,1,0,1,1,0}, 2, 1'b0);
    // R5: budget of one runs out after client 1
    run_case("R5", '{16,0,0,0,8,0}, '{1,1,0,1,1,0}, 1, 1'b0);
    // R6: round-robin over odd clients only
    run_case("R6", '{0,0,0,0,0,0}, '{0,1,0,1,0,1}, 0, 1'b0);
    // R7: nobody active
    run_case("R7", '{0,0,0,0,0,0}, '{0,0,0,0,0,0}, 5, 1'b0);
    // R3 boundary: request 1 and request 64
    run_case("R3", '{1,0,0,0,0,64}, '{0,0,0,0,0,0}, 0, 1'b0);
    // R2: second start during run is ignored
    run_case("R2", '{4,0,6,0,0,0}, '{0,0,1,0,1,0}, 3, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule